// File: doc/BRIEF.md
# Multiframe Sample Phase Realigner

This block sits between a slow-clock sample source and a converter link. It keeps the converter's output timing fixed relative to a slow reference clock. Each slow-clock cycle it takes one word that holds several samples of a fast sample stream. It also takes a measured offset X, counted in sample periods, which gives the position of a periodic alignment pulse relative to the reference clock. The block delays the sample stream by D = (S − X) mod S samples, where S is the number of samples in one multiframe. Because the delay can cross word boundaries, every output word is built from samples of the current word and of earlier words.

A word counter marks multiframes, and a sync input resets it. The output carries a strobe on the first word of each multiframe. A new offset is taken only when a multiframe starts, so a phase change never tears a multiframe apart. When the offset changes while the stream is running, the delay simply jumps. Samples are then skipped or sent twice, and a sticky error flag is raised so that the system can reinitialise the stream. With the default parameters a word has 8 samples of 16 bits and a multiframe has 2 words (S = 16).

Top module: `mf_realign`

## Requirements
- R1: While reset is asserted, and in the first cycle after it, `out_word_o`, `sof_o` and `err_o` are all zero.
- R2: A word carries LANES samples. Lane j sits in bits [j*SAMPLE_W +: SAMPLE_W], and lane 0 is the earliest sample in time. Words follow one another in time, one per clock.
- R3: Number the input samples n = LANES*k + j, where k is the word index since reset. The output word registered at the edge that accepts input word k carries, in lane j, sample n − D, with D = (S − X) mod S and X the applied offset for word k. Samples with a negative index read as zero.
- R4: With an applied offset of 0, the output word equals the previous cycle's input word (pass-through, one cycle of latency).
- R5: A word counter counts MF_WORDS words per multiframe and wraps. An asserted `sync_i` makes the next input word position 0. `sof_o` is high exactly on output words whose input word sat at position 0.
- R6: `ofs_i` is loaded into the applied offset in two cases only: at an edge with `sync_i` high, or at the edge that accepts the last word of a multiframe. At all other edges `ofs_i` has no effect on the output.
- R7: A change of applied offset mid-stream shifts the delay at once. A smaller delay drops samples and a larger one repeats samples, exactly as R3 gives with the new D.
- R8: After the first `sync_i`, loading an offset at a multiframe boundary that differs from the applied one sets `err_o` from the next cycle. The flag stays high until `err_clr_i` is high. If a set and a clear happen at the same edge, the set wins. Before the first sync no error is raised.
- R9: Loading an offset through `sync_i` never sets `err_o`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Slow reference clock |
| rst_n | input | 1 | Active-low synchronous reset |
| sync_i | input | 1 | Restarts the multiframe and loads the offset |
| ofs_i | input | OFS_W | Measured alignment-pulse offset X in samples |
| in_word_i | input | LANES*SAMPLE_W | Input sample word, lane 0 earliest |
| err_clr_i | input | 1 | Clears the sticky error flag |
| out_word_o | output | LANES*SAMPLE_W | Realigned sample word |
| sof_o | output | 1 | Start-of-multiframe strobe for `out_word_o` |
| err_o | output | 1 | Sticky flag for an offset change while running |

## Verification
Every sample carries its own stream index plus one, so each output lane shows which sample was picked. A zero shows a read from before the stream began. The offset is swept over all sixteen values after a sync, which separates off-by-one mux and history errors in both words of the window. Two mid-stream changes (3 to 9 and 9 to 1) show the dropped and the repeated samples, and the error set and clear ordering. An offset pulsed away from the boundary, and offsets changed before any sync, show that the load window and the error gating keep out stray changes.

// File: rtl/sprl_pkg.sv
package sprl_pkg;
    typedef enum logic {
        RUN_OFF = 1'b0,
        RUN_ON  = 1'b1
    } run_e;
endpackage

// File: rtl/mf_realign_ctrl.sv
module mf_realign_ctrl
    import sprl_pkg::*;
#(
    parameter int LANES    = 8,
    parameter int MF_WORDS = 2,
    localparam int SPM     = LANES * MF_WORDS,
    localparam int OFS_W   = $clog2(SPM),
    localparam int WC_W    = (MF_WORDS > 1) ? $clog2(MF_WORDS) : 1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             sync_i,
    input  logic [OFS_W-1:0] ofs_i,
    input  logic             err_clr_i,
    output logic             pos0_o,
    output logic [OFS_W-1:0] shift_o,
    output logic [OFS_W-1:0] ofs_appl_o,
    output logic             err_o
);
    typedef struct packed {
        logic [WC_W-1:0]  wcnt;
        logic [OFS_W-1:0] ofs;
        run_e             run;
        logic             err;
    } ctrl_t;

    ctrl_t st_d, st_q;
    logic  last_word;
    logic  err_set;
    logic [OFS_W:0] neg_ofs;

    always_comb begin
        st_d      = st_q;
        last_word = (st_q.wcnt == WC_W'(MF_WORDS - 1));
        err_set   = 1'b0;
        if (sync_i) begin
            st_d.wcnt = '0;
            st_d.ofs  = ofs_i;
            st_d.run  = RUN_ON;
        end else if (last_word) begin
            st_d.wcnt = '0;
            st_d.ofs  = ofs_i;
            err_set   = (st_q.run == RUN_ON) && (ofs_i != st_q.ofs);
        end else begin
            st_d.wcnt = st_q.wcnt + WC_W'(1);
        end
        if (err_set) begin
            st_d.err = 1'b1;
        end else if (err_clr_i) begin
            st_d.err = 1'b0;
        end
        neg_ofs = (OFS_W + 1)'(SPM) - {1'b0, st_q.ofs};
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '{wcnt: '0, ofs: '0, run: RUN_OFF, err: 1'b0};
        end else begin
            st_q <= st_d;
        end
    end

    assign pos0_o     = (st_q.wcnt == '0);
    assign shift_o    = neg_ofs[OFS_W-1:0];
    assign ofs_appl_o = st_q.ofs;
    assign err_o      = st_q.err;

    // R5
    wcnt_zero_after_sync_chk: assert property (@(posedge clk) disable iff (!rst_n)
        sync_i |=> (st_q.wcnt == '0));

    // R6
    ofs_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!sync_i && (st_q.wcnt != WC_W'(MF_WORDS - 1))) |=> $stable(st_q.ofs));

    // R8
    err_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q.err && !err_clr_i) |=> st_q.err);

    // R9
    no_err_on_sync_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (sync_i && !st_q.err) |=> !st_q.err);
endmodule

// File: rtl/mf_realign_hist.sv
module mf_realign_hist #(
    parameter int LANES    = 8,
    parameter int SAMPLE_W = 16,
    parameter int MF_WORDS = 2,
    localparam int WORD_W  = LANES * SAMPLE_W,
    localparam int WIN_W   = (MF_WORDS + 1) * WORD_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [WORD_W-1:0] word_i,
    output logic [WIN_W-1:0]  window_o
);
    // index MF_WORDS-1 holds the newest past word, index 0 the oldest
    logic [MF_WORDS-1:0][WORD_W-1:0] hist_d, hist_q;

    generate
        if (MF_WORDS == 1) begin : g_one
            always_comb hist_d = word_i;
        end else begin : g_many
            always_comb hist_d = {word_i, hist_q[MF_WORDS-1:1]};
        end
    endgenerate

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            hist_q <= '0;
        end else begin
            hist_q <= hist_d;
        end
    end

    assign window_o = {word_i, hist_q};

    // R2
    hist_shift_chk: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> (window_o[MF_WORDS*WORD_W-1 -: WORD_W] == $past(word_i)));
endmodule

// File: rtl/mf_realign_mux.sv
module mf_realign_mux #(
    parameter int LANES    = 8,
    parameter int SAMPLE_W = 16,
    parameter int MF_WORDS = 2,
    localparam int SPM     = LANES * MF_WORDS,
    localparam int OFS_W   = $clog2(SPM),
    localparam int WORD_W  = LANES * SAMPLE_W,
    localparam int WIN_W   = (MF_WORDS + 1) * WORD_W
) (
    input  logic [WIN_W-1:0]  window_i,
    input  logic [OFS_W-1:0]  shift_i,
    output logic [WORD_W-1:0] word_o
);
    generate
        for (genvar j = 0; j < LANES; j++) begin : g_lane
            int src;
            always_comb begin
                src = MF_WORDS * LANES + j - int'(shift_i);
                word_o[j*SAMPLE_W +: SAMPLE_W] = window_i[src*SAMPLE_W +: SAMPLE_W];
            end
        end
    endgenerate
endmodule

// File: rtl/mf_realign.sv
module mf_realign #(
    parameter int LANES    = 8,
    parameter int SAMPLE_W = 16,
    parameter int MF_WORDS = 2,
    localparam int SPM     = LANES * MF_WORDS,
    localparam int OFS_W   = $clog2(SPM),
    localparam int WORD_W  = LANES * SAMPLE_W,
    localparam int WIN_W   = (MF_WORDS + 1) * WORD_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              sync_i,
    input  logic [OFS_W-1:0]  ofs_i,
    input  logic [WORD_W-1:0] in_word_i,
    input  logic              err_clr_i,
    output logic [WORD_W-1:0] out_word_o,
    output logic              sof_o,
    output logic              err_o
);
    typedef struct packed {
        logic [WORD_W-1:0] word;
        logic              sof;
    } out_t;

    out_t              out_d, out_q;
    logic              pos0;
    logic [OFS_W-1:0]  shift;
    logic [OFS_W-1:0]  ofs_appl;
    logic [WIN_W-1:0]  window;
    logic [WORD_W-1:0] mux_word;

    mf_realign_ctrl #(.LANES(LANES), .MF_WORDS(MF_WORDS)) u_ctrl (
        .clk        (clk),
        .rst_n      (rst_n),
        .sync_i     (sync_i),
        .ofs_i      (ofs_i),
        .err_clr_i  (err_clr_i),
        .pos0_o     (pos0),
        .shift_o    (shift),
        .ofs_appl_o (ofs_appl),
        .err_o      (err_o)
    );

    mf_realign_hist #(.LANES(LANES), .SAMPLE_W(SAMPLE_W), .MF_WORDS(MF_WORDS)) u_hist (
        .clk      (clk),
        .rst_n    (rst_n),
        .word_i   (in_word_i),
        .window_o (window)
    );

    mf_realign_mux #(.LANES(LANES), .SAMPLE_W(SAMPLE_W), .MF_WORDS(MF_WORDS)) u_mux (
        .window_i (window),
        .shift_i  (shift),
        .word_o   (mux_word)
    );

    always_comb begin
        out_d      = out_q;
        out_d.word = mux_word;
        out_d.sof  = pos0;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            out_q <= '0;
        end else begin
            out_q <= out_d;
        end
    end

    assign out_word_o = out_q.word;
    assign sof_o      = out_q.sof;

    // R4
    pass_through_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (ofs_appl == '0) |=> (out_word_o == $past(in_word_i)));

    // R5
    sof_after_sync_chk: assert property (@(posedge clk) disable iff (!rst_n)
        sync_i |=> ##1 sof_o);
endmodule

// File: tb/mf_realign_bench.sv
module mf_realign_bench;
    localparam int LANES = 8;
    localparam int SW    = 16;
    localparam int MFW   = 2;
    localparam int SPM   = LANES * MFW;
    localparam int OW    = $clog2(SPM);
    localparam int WW    = LANES * SW;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          sync_i = 1'b0;
    logic [OW-1:0] ofs_i = '0;
    logic [WW-1:0] in_word_i = '0;
    logic          err_clr_i = 1'b0;
    logic [WW-1:0] out_word_o;
    logic          sof_o;
    logic          err_o;

    int checks = 0;
    int failures = 0;
    bit done = 1'b0;

    int m_k, m_wpos, m_appl, m_run, m_err;

    always #10 clk = ~clk;

    mf_realign #(.LANES(LANES), .SAMPLE_W(SW), .MF_WORDS(MFW)) u_mf_realign (
        .clk(clk), .rst_n(rst_n), .sync_i(sync_i), .ofs_i(ofs_i),
        .in_word_i(in_word_i), .err_clr_i(err_clr_i),
        .out_word_o(out_word_o), .sof_o(sof_o), .err_o(err_o)
    );

    function automatic logic [WW-1:0] mk_word(int k);
        logic [WW-1:0] w;
        for (int j = 0; j < LANES; j++) w[j*SW +: SW] = SW'(k * LANES + j + 1);
        return w;
    endfunction

    task automatic chk(string tag, string what, logic [WW-1:0] got, logic [WW-1:0] exp);
        checks++;
        if (got !== exp) begin
            failures++;
            $display("FAIL %s %s: got %h exp %h", tag, what, got, exp);
        end
    endtask

    task automatic do_reset();
        rst_n = 1'b0; sync_i = 1'b0; ofs_i = '0; err_clr_i = 1'b0; in_word_i = '0;
        repeat (3) @(negedge clk);
        // R1: outputs idle in reset
        chk("R1", "word", out_word_o, '0);
        chk("R1", "sof", WW'(sof_o), '0);
        chk("R1", "err", WW'(err_o), '0);
        rst_n = 1'b1;
        m_k = 0; m_wpos = 0; m_appl = 0; m_run = 0; m_err = 0;
    endtask

    // drives one word, updates the model, checks outputs one cycle later
    task automatic cyc(bit s, int ofs, bit clr, string tag, string etag);
        logic [WW-1:0] exp_w;
        int d, idx, set;
        bit exp_sof;
        sync_i = s; ofs_i = OW'(ofs); err_clr_i = clr; in_word_i = mk_word(m_k);
        d = (SPM - m_appl) % SPM;
        for (int j = 0; j < LANES; j++) begin
            idx = m_k * LANES + j - d;
            exp_w[j*SW +: SW] = (idx < 0) ? '0 : SW'(idx + 1);
        end
        exp_sof = (m_wpos == 0);
        set = 0;
        if (s) begin
            m_wpos = 0; m_appl = ofs; m_run = 1;
        end else if (m_wpos == MFW - 1) begin
            if (m_run != 0 && ofs != m_appl) set = 1;
            m_wpos = 0; m_appl = ofs;
        end else begin
            m_wpos++;
        end
        if (set != 0) m_err = 1;
        else if (clr) m_err = 0;
        m_k++;
        @(negedge clk);
        chk(tag, "word", out_word_o, exp_w);
        chk("R5", "sof", WW'(sof_o), WW'(exp_sof));
        chk(etag, "err", WW'(err_o), WW'(m_err));
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            failures++;
            $display("FAIL watchdog: got timeout exp completion");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        do_reset();
        // R6 / R8: offsets before any sync load at boundaries, no error
        for (int i = 0; i < 6; i++) cyc(1'b0, 5 + i, 1'b0, "R6", "R8");
        // R4: pass-through after sync with offset 0
        cyc(1'b1, 0, 1'b0, "R6", "R9");
        for (int i = 0; i < 6; i++) cyc(1'b0, 0, 1'b0, "R4", "R8");
        // R3 / R9: sweep all offsets, each loaded by sync
        for (int x = 0; x < SPM; x++) begin
            cyc(1'b1, x, 1'b0, "R3", "R9");
            for (int i = 0; i < 5; i++) cyc(1'b0, x, 1'b0, "R3", "R8");
        end
        // R6: pulse a different offset away from the boundary
        cyc(1'b1, 3, 1'b0, "R3", "R9");
        for (int i = 0; i < 6; i++)
            cyc(1'b0, (m_wpos == 0) ? 9 : 3, 1'b0, "R6", "R8");
        // R7: 3 -> 9 shrinks the delay (drop), error is raised and held
        for (int i = 0; i < 6; i++) cyc(1'b0, 9, 1'b0, "R7", "R8");
        cyc(1'b0, 9, 1'b1, "R7", "R8");
        cyc(1'b0, 9, 1'b0, "R7", "R8");
        // R7: 9 -> 1 grows the delay (repeat); set beats clear at the same edge
        while (m_wpos != MFW - 1) cyc(1'b0, 9, 1'b0, "R7", "R8");
        cyc(1'b0, 1, 1'b1, "R7", "R8");
        for (int i = 0; i < 5; i++) cyc(1'b0, 1, 1'b0, "R7", "R8");
        cyc(1'b0, 1, 1'b1, "R7", "R8");
        // R9: sync with a new offset leaves err clear
        cyc(1'b1, 12, 1'b0, "R3", "R9");
        for (int i = 0; i < 4; i++) cyc(1'b0, 12, 1'b0, "R3", "R9");
        // R1: reset again and check post-reset state
        do_reset();
        cyc(1'b0, 0, 1'b0, "R1", "R1");
        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule